// File: doc/BRIEF.md
# Wake-on-pin-change detector

This block watches a selected subset of an input port while the core is asleep and requests a wake-up when any watched pin no longer matches the value that software last saw. The comparison reference is not the previous clock's pin value. It is a snapshot taken whenever the port is read or touched by a file or bit access. A pin edge that software never read therefore stays pending. The next time the core enters sleep with the feature enabled, that pending edge wakes it straight away, even if the pins stay quiet during sleep.

Every watched pin passes through a two-flop synchronizer before any comparison. A read strobe from the core loads the snapshot register. The mismatch result is always visible to the status controller. A wake request is raised only while sleep is active and the wake-on-change enable is set.

Top module: `pinchg_wake`

## Requirements
- R1: Only port bits 0, 1, 3 and 4 are watched; toggling bits 2, 5, 6 and 7 never changes `mismatch` or `wake_req`.
- R2: A watched pin passes through two synchronizer flops. A change applied to `pin_raw` before clock edge N reaches `mismatch` after edge N+1, and has no effect after edge N alone.
- R3: When `port_rd` is high at a clock edge, the snapshot loads the synchronized watched pins. If the pins are stable, `mismatch` is low after that edge.
- R4: `mismatch` is high exactly when the synchronized watched pins differ from the snapshot, whatever the values of `sleep_act` and `wake_en`.
- R5: `wake_req` is high exactly when `mismatch`, `wake_en` and `sleep_act` are all high. It follows `sleep_act` and `wake_en` in the same cycle, with no register in between.
- R6: If a watched pin changed and the port was not read again, `wake_req` rises in the same cycle that `sleep_act` rises, even with no pin activity during sleep.
- R7: While `wake_en` is low, `wake_req` stays low whatever the pins do.
- R8: A synchronous active-low reset clears the snapshot and the synchronizers to zero. `mismatch` is low after reset and stays low until a watched pin reads as 1 or the snapshot is reloaded.
- R9: A read while a pin is still inside the synchronizer captures the synchronized value, not the raw one. The late-arriving change then shows up as a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_raw | input | 8 | Asynchronous port pin levels |
| port_rd | input | 1 | Strobe: the port was read or accessed by a file/bit operation |
| wake_en | input | 1 | Wake-on-change enable |
| sleep_act | input | 1 | Core is in sleep |
| wake_req | output | 1 | Wake request to the power controller |
| mismatch | output | 1 | Watched pins differ from the last-read snapshot |

## Verification
A pin change is due at `mismatch` two clock edges after it is applied. A snapshot load from `port_rd` takes effect one edge after the strobe. `wake_req` follows `sleep_act` and `wake_en` within the same cycle. The bench drives every input just after a falling edge and samples both outputs shortly afterwards. It compares them with a register-level reference model that shifts on the same rising edges, so every sample falls at the point where each result is settled. Directed cases pin down the exact edge on which a change appears (R2), the immediate wake on entering sleep (R6) and the read that races a pin (R9).

// File: rtl/wake_pkg.sv
// Package: shared parameters and helpers for the wake-on-pin-change detector.
// Assumes an 8-bit port with a fixed default watch mask.
package wake_pkg;
    localparam int          PORT_W_DEF     = 8;
    localparam logic [7:0]  WATCH_MASK_DEF = 8'b0001_1011;
    localparam int          SYNC_DEF       = 2;

    // Count of watched bits in a mask.
    function automatic int watched_bits(input logic [31:0] m);
        int n;
        n = 0;
        for (int i = 0; i < 32; i++) n += int'(m[i]);
        return n;
    endfunction
endpackage

// File: rtl/pin_sync.sv
// Module: per-bit synchronizer chain for watched port pins.
// Bits outside WATCH get no flops and read as 0. Assumes SYNC_STAGES >= 2.
module pin_sync #(
    parameter int              PORT_W      = 8,
    parameter logic [PORT_W-1:0] WATCH     = '1,
    parameter int              SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] pin_i,
    output logic [PORT_W-1:0] sync_o
);
    localparam int LAST = SYNC_STAGES - 1;

    for (genvar b = 0; b < PORT_W; b++) begin : g_bit
        if (WATCH[b]) begin : g_on
            logic [SYNC_STAGES-1:0] chain;

            // Shift the raw pin level through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[SYNC_STAGES-2:0], pin_i[b]};
            end

            assign sync_o[b] = chain[LAST];

            if (SYNC_STAGES == 2) begin : g_lat_chk
                // R2
                sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    ($past(rst_n) && $past(rst_n, 2)) |-> (sync_o[b] == $past(pin_i[b], 2)));
            end
        end else begin : g_off
            logic unused_pin;
            assign unused_pin = pin_i[b];
            assign sync_o[b]  = 1'b0;
        end
    end
endmodule

// File: rtl/snap_reg.sv
// Module: last-read snapshot of the watched pins.
// Loads the synchronized pin values on each port access strobe; holds otherwise.
module snap_reg #(
    parameter int                PORT_W = 8,
    parameter logic [PORT_W-1:0] WATCH  = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [PORT_W-1:0] sync_i,
    output logic [PORT_W-1:0] snap_o
);
    for (genvar b = 0; b < PORT_W; b++) begin : g_bit
        if (WATCH[b]) begin : g_on
            // Capture the synchronized bit on a port access.
            always_ff @(posedge clk) begin
                if (!rst_n)      snap_o[b] <= 1'b0;
                else if (load_i) snap_o[b] <= sync_i[b];
            end
        end else begin : g_off
            assign snap_o[b] = 1'b0;
        end
    end

    // R3
    snap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (snap_o == ($past(sync_i) & WATCH)));
    // R3
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && $past(rst_n)) |=> $stable(snap_o));
    // R8
    snap_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (snap_o == '0));
endmodule

// File: rtl/chg_cmp.sv
// Module: compares synchronized pins with the snapshot and gates the wake request.
// Purely combinational; both vectors already carry zeros in unwatched bits.
module chg_cmp #(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] sync_i,
    input  logic [PORT_W-1:0] snap_i,
    input  logic              wake_en_i,
    input  logic              sleep_i,
    output logic              mismatch_o,
    output logic              wake_o
);
    logic [PORT_W-1:0] diff;

    // Flag any differing bit and qualify it with sleep and enable.
    always_comb begin
        diff       = sync_i ^ snap_i;
        mismatch_o = |diff;
        wake_o     = mismatch_o && wake_en_i && sleep_i;
    end

    // R7
    wake_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_en_i |-> !wake_o);
    // R5
    wake_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (sleep_i && mismatch_o));
endmodule

// File: rtl/pinchg_wake.sv
// Module: top of the wake-on-pin-change detector.
// Synchronizes the port, keeps a last-read snapshot and raises a wake request
// while asleep when the watched pins differ from that snapshot.
// Assumes port_rd, wake_en and sleep_act are already in the clk domain.
module pinchg_wake
    import wake_pkg::*;
#(
    parameter int                PORT_W      = PORT_W_DEF,
    parameter logic [PORT_W-1:0] WATCH_MASK  = WATCH_MASK_DEF,
    parameter int                SYNC_STAGES = SYNC_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] pin_raw,
    input  logic              port_rd,
    input  logic              wake_en,
    input  logic              sleep_act,
    output logic              wake_req,
    output logic              mismatch
);
    localparam int N_WATCH = watched_bits(32'(WATCH_MASK));

    logic [PORT_W-1:0] pin_sync_v;
    logic [PORT_W-1:0] snap_v;

    pin_sync #(.PORT_W(PORT_W), .WATCH(WATCH_MASK), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_raw), .sync_o(pin_sync_v)
    );

    snap_reg #(.PORT_W(PORT_W), .WATCH(WATCH_MASK)) u_snap (
        .clk(clk), .rst_n(rst_n), .load_i(port_rd), .sync_i(pin_sync_v), .snap_o(snap_v)
    );

    chg_cmp #(.PORT_W(PORT_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .sync_i(pin_sync_v), .snap_i(snap_v),
        .wake_en_i(wake_en), .sleep_i(sleep_act),
        .mismatch_o(mismatch), .wake_o(wake_req)
    );

    // Elaboration-time sanity check of the parameters.
    initial begin
        if (N_WATCH == 0 || SYNC_STAGES < 2)
            $error("pinchg_wake: bad parameters");
    end

    // R1
    unwatched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_sync_v & ~WATCH_MASK) == '0) && ((snap_v & ~WATCH_MASK) == '0));
    // R3
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd && $stable(pin_sync_v) && $past(rst_n)) |=> (!mismatch || $changed(pin_sync_v)));
    // R6
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sleep_act) && wake_en && mismatch) |-> wake_req);
endmodule

// File: tb/tb_pinchg_wake.sv
// Bench: random plus directed stimulus, checked against a register-level model.
module tb_pinchg_wake;
    localparam int         CLK_PER = 10;
    localparam logic [7:0] WM      = 8'b0001_1011;

    logic       clk = 0;
    logic       rst_n = 0;
    logic [7:0] pin_raw = 0;
    logic       port_rd = 0, wake_en = 0, sleep_act = 0;
    logic       wake_req, mismatch;

    int total = 0, bad = 0;
    bit done = 0;

    pinchg_wake dut (.clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .port_rd(port_rd),
                     .wake_en(wake_en), .sleep_act(sleep_act),
                     .wake_req(wake_req), .mismatch(mismatch));

    always #(CLK_PER/2) clk = ~clk;

    // Reference model state
    logic [7:0] m_s1 = 0, m_s2 = 0, m_ref = 0;
    always @(posedge clk) begin
        if (!rst_n) begin m_s1 <= 0; m_s2 <= 0; m_ref <= 0; end
        else begin
            m_s1 <= pin_raw & WM;
            m_s2 <= m_s1;
            if (port_rd) m_ref <= m_s2;
        end
    end

    function automatic logic exp_mm();
        return (m_s2 != m_ref);
    endfunction
    function automatic logic exp_wk();
        return exp_mm() && wake_en && sleep_act;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    // Drive after a falling edge, then compare both outputs with the model.
    task automatic step(input logic [7:0] p, input logic rd, input logic en, input logic sl,
                        input string req);
        @(negedge clk);
        pin_raw = p; port_rd = rd; wake_en = en; sleep_act = sl;
        #1;
        chk({req, " mismatch"}, mismatch, exp_mm());
        chk({req, " wake_req"}, wake_req, exp_wk());
    endtask

    initial begin
        #(CLK_PER * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        pin_raw = 8'hFF;
        repeat (3) @(negedge clk);
        #1;
        // R8: reset state
        chk("R8 reset mismatch", mismatch, 1'b0);
        chk("R8 reset wake", wake_req, 1'b0);
        rst_n = 1; pin_raw = 0;
        step(8'h00, 0, 1, 1, "R8");
        step(8'h00, 0, 1, 1, "R8");
        chk("R8 idle after reset", mismatch, 1'b0);

        // R1: unwatched bits toggle freely
        for (int i = 0; i < 6; i++) begin
            step(8'hE4 ^ {8{i[0]}} & 8'hE4, 0, 1, 1, "R1");
            chk("R1 no mismatch", mismatch, 1'b0);
            chk("R1 no wake", wake_req, 1'b0);
        end

        // R2: change appears after exactly two edges
        step(8'h01, 0, 1, 0, "R2");
        step(8'h01, 0, 1, 0, "R2");
        chk("R2 one edge", mismatch, 1'b0);
        step(8'h01, 0, 1, 0, "R2");
        chk("R2 two edges", mismatch, 1'b1);
        // R4: mismatch visible outside sleep, no wake
        chk("R4 awake mismatch", mismatch, 1'b1);
        chk("R5 awake no wake", wake_req, 1'b0);
        // R6: entering sleep with unread change wakes at once
        step(8'h01, 0, 1, 1, "R6");
        chk("R6 immediate wake", wake_req, 1'b1);
        // R7: enable low forces wake low
        step(8'h01, 0, 0, 1, "R7");
        chk("R7 disabled", wake_req, 1'b0);
        // R3: read clears mismatch one edge later
        step(8'h01, 1, 1, 0, "R3");
        step(8'h01, 0, 1, 1, "R3");
        chk("R3 cleared", mismatch, 1'b0);
        chk("R3 no wake after read", wake_req, 1'b0);

        // R9: read while change is in the synchronizer
        step(8'h19, 0, 1, 0, "R9");
        step(8'h19, 1, 1, 0, "R9");
        step(8'h19, 0, 1, 0, "R9");
        step(8'h19, 0, 1, 1, "R9");
        chk("R9 late change wakes", wake_req, 1'b1);
        step(8'h19, 1, 1, 1, "R9");
        step(8'h19, 0, 1, 1, "R9");
        chk("R9 settled", mismatch, 1'b0);

        // Random phase, all requirements against the model (R4 R5)
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] p;
            p = ($urandom % 4 == 0) ? 8'($urandom) : pin_raw;
            step(p, ($urandom % 5) == 0, ($urandom % 4) != 0, ($urandom % 2) == 0, "R4R5 rand");
        end

        // R8: reset mid-run clears the snapshot
        @(negedge clk); rst_n = 0; pin_raw = 8'h1B;
        step(8'h1B, 0, 1, 1, "R8");
        step(8'h1B, 0, 1, 1, "R8");
        rst_n = 1;
        step(8'h1B, 0, 1, 1, "R8");
        step(8'h1B, 0, 1, 1, "R8");
        chk("R8 pins high after reset", mismatch, 1'b1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule